// File: doc/BRIEF.md
# Edge-Selectable Interrupt Register Block

This block is the interrupt unit of a register-mapped peripheral. It watches sixteen internal event lines, among them a conversion-complete line from the converter and the comparator on the positive X touch plate. Each line can be armed to record a low-to-high transition, a high-to-low transition, or either, using two independent enable registers. Recorded events are sticky. They are collected in a status register and combined onto one interrupt output.

Software reaches the block through a plain register port with a 7-bit address and 16-bit data. Writes are strobed and reads are combinational. The status address is also the clear address. Writing a word clears every status bit that is 1 in that word. The follow-up write of zero that software issues afterwards leaves the status register unchanged. Each source is compared against a registered copy of its previous value, so an enabled transition is recorded at the first clock edge after it appears.

Top module: `tsi_irq_unit`

## Requirements
- R1: After reset both enable registers and the status register read 0 and `irq` is low.
- R2: The rising-edge enable register is written and read at address 0x5E, and the falling-edge enable register is written and read at address 0x60. Bit n of each register controls event line n.
- R3: A low-to-high change on an event line whose rising enable bit is 1 sets that line's status bit at the next clock edge.
- R4: A high-to-low change on an event line whose falling enable bit is 1 sets that line's status bit at the next clock edge.
- R5: With both enable bits of a line set, either direction of change sets its status bit. With only one enable bit set, the other direction sets nothing.
- R6: While both enable registers are zero, no status bit becomes set, whatever the event lines do.
- R7: The status register reads at address 0x62. Bit 11 records the conversion-complete line (`evt[11]`) and bit 12 records the positive X touch-plate line (`evt[12]`).
- R8: A write to 0x62 clears exactly the status bits that are 1 in the write data. Writing zero to 0x62 changes nothing.
- R9: If an enabled edge arrives in the same cycle as a clear of that bit, the bit remains set.
- R10: `irq` is high whenever any status bit is set. It stays high after the source returns to its old level, and it falls only after a clear write.
- R11: Reads of any other address return 0, and writes to any other address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 7 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| evt | input | 16 | Internal event lines |
| irq | output | 1 | Interrupt, OR of all status bits |

## Verification
A wrong stored previous value on a line shows up as a spurious or missing status bit. That bit is visible at `rdata` on the status address and on `irq` one clock after the offending change. A stale enable bit shows up the same way, and a clear that reaches the wrong bits shows up on the readback right after the clear write. The sweep drives each line, in each enable mode and each direction, against a clean status register. Any of these faults therefore appears as a single-bit mismatch within two cycles of the stimulus.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] RISE_EN_ADDR = 7'h5E;
    localparam logic [ADDR_W-1:0] FALL_EN_ADDR = 7'h60;
    localparam logic [ADDR_W-1:0] STATUS_ADDR  = 7'h62;

    localparam int CONV_DONE_BIT = 11;
    localparam int TOUCH_PX_BIT  = 12;
endpackage

// File: rtl/tsi_edge_det.sv
module tsi_edge_det #(
    parameter int W = tsi_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    output logic [W-1:0] hit,
    output logic [W-1:0] prev
);
    typedef struct packed {
        logic [W-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // One detector per line; both polarities are checked independently.
    for (genvar i = 0; i < W; i++) begin : g_line
        logic went_up, went_down;
        assign went_up   =  evt[i] & ~st_q.prev[i];
        assign went_down = ~evt[i] &  st_q.prev[i];
        assign hit[i]    = (rise_en[i] & went_up) | (fall_en[i] & went_down);
    end

    assign prev = st_q.prev;
endmodule

// File: rtl/tsi_cfg_regs.sv
module tsi_cfg_regs #(
    parameter int                DW        = tsi_pkg::DATA_W,
    parameter int                AW        = tsi_pkg::ADDR_W,
    parameter logic [AW-1:0]     RISE_ADDR = tsi_pkg::RISE_EN_ADDR,
    parameter logic [AW-1:0]     FALL_ADDR = tsi_pkg::FALL_EN_ADDR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rise_en,
    output logic [DW-1:0] fall_en
);
    typedef struct packed {
        logic [DW-1:0] rise;
        logic [DW-1:0] fall;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && addr == RISE_ADDR) st_d.rise = wdata;
        if (wr_en && addr == FALL_ADDR) st_d.fall = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_en = st_q.rise;
    assign fall_en = st_q.fall;
endmodule

// File: rtl/tsi_status.sv
module tsi_status #(
    parameter int DW = tsi_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] hit,
    input  logic          clr_stb,
    input  logic [DW-1:0] clr_mask,
    output logic [DW-1:0] status,
    output logic          irq
);
    typedef struct packed {
        logic [DW-1:0] bits;
    } stat_st_t;

    stat_st_t      st_d, st_q;
    logic [DW-1:0] kill;

    always_comb begin
        st_d = st_q;
        kill = clr_stb ? clr_mask : '0;
        // A fresh hit is OR-ed in after the clear, so it survives it.
        st_d.bits = (st_q.bits & ~kill) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.bits;
    assign irq    = |st_q.bits;
endmodule

// File: rtl/tsi_irq_unit.sv
module tsi_irq_unit #(
    parameter int                DW        = tsi_pkg::DATA_W,
    parameter int                AW        = tsi_pkg::ADDR_W,
    parameter logic [AW-1:0]     RISE_ADDR = tsi_pkg::RISE_EN_ADDR,
    parameter logic [AW-1:0]     FALL_ADDR = tsi_pkg::FALL_EN_ADDR,
    parameter logic [AW-1:0]     STAT_ADDR = tsi_pkg::STATUS_ADDR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] evt,
    output logic          irq
);
    logic [DW-1:0] rise_w, fall_w, hit_w, prev_w, status_w;
    logic          clr_stb;

    assign clr_stb = wr_en && (addr == STAT_ADDR);

    tsi_cfg_regs #(
        .DW(DW), .AW(AW), .RISE_ADDR(RISE_ADDR), .FALL_ADDR(FALL_ADDR)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rise_en(rise_w), .fall_en(fall_w)
    );

    tsi_edge_det #(.W(DW)) u_edge (
        .clk(clk), .rst_n(rst_n), .evt(evt), .rise_en(rise_w),
        .fall_en(fall_w), .hit(hit_w), .prev(prev_w)
    );

    tsi_status #(.DW(DW)) u_stat (
        .clk(clk), .rst_n(rst_n), .hit(hit_w), .clr_stb(clr_stb),
        .clr_mask(wdata), .status(status_w), .irq(irq)
    );

    always_comb begin
        unique case (addr)
            RISE_ADDR: rdata = rise_w;
            FALL_ADDR: rdata = fall_w;
            STAT_ADDR: rdata = status_w;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/tsi_irq_chk.sv
module tsi_irq_chk #(
    parameter int            DW        = tsi_pkg::DATA_W,
    parameter int            AW        = tsi_pkg::ADDR_W,
    parameter logic [AW-1:0] RISE_ADDR = tsi_pkg::RISE_EN_ADDR,
    parameter logic [AW-1:0] STAT_ADDR = tsi_pkg::STATUS_ADDR
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          wr_en,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] evt,
    input logic          irq,
    input logic [DW-1:0] status_q,
    input logic [DW-1:0] prev_q,
    input logic [DW-1:0] rise_q,
    input logic [DW-1:0] fall_q
);
    assert_rise_reg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RISE_ADDR) |=> (rise_q == $past(wdata)));

    assert_new_bit_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~($past(rise_q) | $past(fall_q))) == '0));

    assert_new_bit_transition_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~($past(evt) ^ $past(prev_q))) == '0));

    assert_idle_no_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_q == '0 && fall_q == '0) |=> ((status_q & ~$past(status_q)) == '0));

    assert_zero_clear_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == STAT_ADDR && wdata == '0) |=>
        ((status_q & $past(status_q)) == $past(status_q)));

    assert_irq_drop_needs_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_en && addr == STAT_ADDR));
endmodule

bind tsi_irq_unit tsi_irq_chk #(
    .DW(DW), .AW(AW), .RISE_ADDR(RISE_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .evt(evt), .irq(irq), .status_q(status_w), .prev_q(prev_w),
    .rise_q(rise_w), .fall_q(fall_w)
);

// File: tb/sim_tsi_irq_unit.sv
module sim_tsi_irq_unit;
    localparam logic [6:0] A_RISE = 7'h5E;
    localparam logic [6:0] A_FALL = 7'h60;
    localparam logic [6:0] A_STAT = 7'h62;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [15:0] evt = '0;
    logic        irq;

    int vectors = 0;
    int fails = 0;

    always #2 clk = ~clk;

    tsi_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .evt(evt), .irq(irq)
    );

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; addr = '0;
    endtask

    task automatic set_evt(input logic [15:0] v);
        @(negedge clk);
        evt = v;
        @(negedge clk);
    endtask

    task automatic chk_rd(input logic [6:0] a, input logic [15:0] exp, input string tag);
        addr = a;
        #1;
        vectors++;
        if (rdata !== exp) begin
            fails++;
            $display("FAIL %s: read %h got %h expected %h", tag, a, rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        vectors++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s: irq got %b expected %b", tag, irq, exp);
        end
    endtask

    task automatic clean();
        wr(A_RISE, 16'h0);
        wr(A_FALL, 16'h0);
        wr(A_STAT, 16'hFFFF);
        wr(A_STAT, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_rd(A_RISE, 16'h0, "R1");
        chk_rd(A_FALL, 16'h0, "R1");
        chk_rd(A_STAT, 16'h0, "R1");
        chk_irq(1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);

        // R2: enable register readback
        wr(A_RISE, 16'hA5C3);
        wr(A_FALL, 16'h3C5A);
        chk_rd(A_RISE, 16'hA5C3, "R2");
        chk_rd(A_FALL, 16'h3C5A, "R2");

        // R11: other addresses read zero, writes there touch nothing
        wr(7'h10, 16'hFFFF);
        wr(7'h5F, 16'hFFFF);
        chk_rd(7'h10, 16'h0, "R11");
        chk_rd(7'h7F, 16'h0, "R11");
        chk_rd(A_RISE, 16'hA5C3, "R11");
        chk_rd(A_FALL, 16'h3C5A, "R11");

        // Sweep: every line, every enable mode, both directions (R3 R4 R5 R6)
        for (int b = 0; b < 16; b++) begin
            for (int m = 0; m < 4; m++) begin
                for (int up = 0; up < 2; up++) begin
                    logic [15:0] one, exp;
                    string tag;
                    one = 16'h1 << b;
                    clean();
                    set_evt(up != 0 ? 16'h0 : one);
                    wr(A_RISE, m[0] ? one : 16'h0);
                    wr(A_FALL, m[1] ? one : 16'h0);
                    set_evt(up != 0 ? one : 16'h0);
                    exp = ((up != 0) ? m[0] : m[1]) ? one : 16'h0;
                    if (m == 0)      tag = "R6";
                    else if (m == 3) tag = "R5";
                    else if (up != 0) tag = "R3";
                    else             tag = "R4";
                    chk_rd(A_STAT, exp, tag);
                    chk_irq(exp != 0, tag);
                end
            end
        end

        // R6: all lines toggling with both enables zero
        clean();
        set_evt(16'hFFFF);
        set_evt(16'h0);
        set_evt(16'h5555);
        chk_rd(A_STAT, 16'h0, "R6");

        // R7: conversion-done and touch-plate bit positions
        clean();
        set_evt(16'h0);
        wr(A_RISE, 16'hFFFF);
        set_evt(16'h0800);
        chk_rd(A_STAT, 16'h0800, "R7");
        set_evt(16'h1800);
        chk_rd(A_STAT, 16'h1800, "R7");

        // R10: sticky after source returns, irq high until cleared
        set_evt(16'h0);
        chk_rd(A_STAT, 16'h1800, "R10");
        chk_irq(1'b1, "R10");

        // R8: zero write keeps, selective clear
        wr(A_STAT, 16'h0);
        chk_rd(A_STAT, 16'h1800, "R8");
        wr(A_STAT, 16'h0800);
        chk_rd(A_STAT, 16'h1000, "R8");
        chk_irq(1'b1, "R10");
        wr(A_STAT, 16'h0);
        chk_rd(A_STAT, 16'h1000, "R8");
        wr(A_STAT, 16'h1000);
        chk_rd(A_STAT, 16'h0, "R8");
        chk_irq(1'b0, "R10");
        wr(A_STAT, 16'h0);

        // R9: edge in the same cycle as a clear of that bit
        set_evt(16'h0);
        @(negedge clk);
        addr = A_STAT; wdata = 16'h1000; wr_en = 1'b1; evt = 16'h1000;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        chk_rd(A_STAT, 16'h1000, "R9");
        // bit already set, cleared while a new edge arrives
        set_evt(16'h0);
        @(negedge clk);
        addr = A_STAT; wdata = 16'h1000; wr_en = 1'b1; evt = 16'h1000;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        chk_rd(A_STAT, 16'h1000, "R9");
        chk_irq(1'b1, "R9");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule